// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block keeps display configuration in two copies. A single-cycle address/data bus writes into a shadow copy, while the display logic sees only the active copy on a flattened output vector. The shadow copy moves into the active copy on a vertical-blank pulse, so a frame never sees a half-written configuration.

Register index 0 is a buffer-control word. It holds an autoload-disable flag and a load request. With autoload enabled, every vblank pulse copies shadow to active. With autoload disabled, software stages its writes and then writes the control word with both bits set in one bus write. The copy then happens on the next vblank, and the load request clears itself on that same clock edge. Software polls the load request until it reads zero before it starts the next update.

The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset, every active slot is zero, every shadow register reads zero, and the control word reads zero (autoload enabled, no load pending).
- R2: A write to index k (1 to NUM_REGS-1) updates that shadow register, which reads back the new value on the next cycle. The active slot k, on bits [(k-1)*DATA_W +: DATA_W] of `active_cfg`, does not change because of the write.
- R3: Index 0 is the control word. Bit 0 is the load request and bit 1 is autoload disable. A read returns the live state of these bits, and all other bits read zero.
- R4: The active copy changes only on the clock edge that samples `vblank` high.
- R5: With autoload disabled and the load request set, a vblank copies every shadow register into the active copy. The load request reads zero from that same edge on.
- R6: With autoload disabled and no load request pending, a vblank leaves the active copy unchanged.
- R7: With autoload enabled, every vblank copies shadow into active, whatever the load request holds. A pending load request is cleared by that vblank.
- R8: Writing the control word with bit 0 clear does not cancel a pending load request. A write that sets bit 0 in the same cycle as a transfer leaves the request set for the next vblank.
- R9: When a shadow write and a transfer fall in the same cycle, the active copy takes the shadow value from before the write, and the shadow keeps the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Register index for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| vblank | input | 1 | Vertical-blank pulse |
| active_cfg | output | (NUM_REGS-1)*DATA_W | Active copies of indices 1 to NUM_REGS-1, index k in slot k-1 |

## Verification
The assertions assume `vblank` is a pulse one cycle wide, sampled as a transfer event on each edge where it is high. They also assume the bus only addresses indices inside the map, so no write is lost to decoding. The stimulus drives every input away from the clock edge and keeps addresses below NUM_REGS. It pulses vblank for single cycles, including in the same cycle as shadow and control writes, so the ordering rules of R8 and R9 are exercised.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int CTRL_IDX  = 0;
  localparam int LOAD_BIT  = 0;
  localparam int ALDIS_BIT = 1;
endpackage

// File: rtl/csb_rst_sync.sv
module csb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/csb_ctrl_reg.sv
module csb_ctrl_reg
  import csb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vblank,
  output logic              load_q,
  output logic              aldis_q,
  output logic              xfer
);
  logic load_d, aldis_d, load_en, aldis_en;

  // transfer decision uses the state held before this edge
  assign xfer = vblank & (~aldis_q | load_q);

  always_comb begin
    aldis_en = ctrl_wr;
    aldis_d  = wr_data[ALDIS_BIT];
    load_en  = ctrl_wr | xfer;
    // a new request written in the transfer cycle survives the clear
    load_d   = (ctrl_wr & wr_data[LOAD_BIT]) | (load_q & ~xfer);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b0;
      aldis_q <= 1'b0;
    end else begin
      if (load_en)  load_q  <= load_d;
      if (aldis_en) aldis_q <= aldis_d;
    end
  end
endmodule

// File: rtl/csb_reg_slot.sv
module csb_reg_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [DATA_W-1:0] shadow_q,
  output logic [DATA_W-1:0] active_q
);
  logic [DATA_W-1:0] shadow_d, active_d;
  logic              shadow_en, active_en;

  always_comb begin
    shadow_en = wr_sel;
    shadow_d  = wr_data;
    active_en = xfer;
    active_d  = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (active_en) active_q <= active_d;
    end
  end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import csb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic                           vblank,
  output logic [(NUM_REGS-1)*DATA_W-1:0] active_cfg
);
  localparam int NSLOT = NUM_REGS - 1;

  logic                    rst_sync_n;
  logic                    load_q, aldis_q, xfer, ctrl_wr;
  logic [DATA_W-1:0]       shadow_arr [NUM_REGS];
  logic [NSLOT*DATA_W-1:0] shadow_flat;

  csb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ctrl_wr = bus_wr & (bus_addr == ADDR_W'(CTRL_IDX));

  csb_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctrl_wr (ctrl_wr),
    .wr_data (bus_wdata),
    .vblank  (vblank),
    .load_q  (load_q),
    .aldis_q (aldis_q),
    .xfer    (xfer)
  );

  assign shadow_arr[0] = '0;

  for (genvar k = 1; k < NUM_REGS; k++) begin : g_slot
    logic wr_sel;
    assign wr_sel = bus_wr & (bus_addr == ADDR_W'(k));
    csb_reg_slot #(.DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_sel   (wr_sel),
      .wr_data  (bus_wdata),
      .xfer     (xfer),
      .shadow_q (shadow_arr[k]),
      .active_q (active_cfg[(k-1)*DATA_W +: DATA_W])
    );
    assign shadow_flat[(k-1)*DATA_W +: DATA_W] = shadow_arr[k];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_IDX)) begin
      bus_rdata[LOAD_BIT]  = load_q;
      bus_rdata[ALDIS_BIT] = aldis_q;
    end else begin
      for (int k = 1; k < NUM_REGS; k++)
        if (bus_addr == ADDR_W'(k)) bus_rdata = shadow_arr[k];
    end
  end
endmodule

// File: rtl/csb_checker.sv
module csb_checker #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input logic                           clk,
  input logic                           rst_sync_n,
  input logic                           vblank,
  input logic                           bus_wr,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic                           load_q,
  input logic                           aldis_q,
  input logic [(NUM_REGS-1)*DATA_W-1:0] active_cfg,
  input logic [(NUM_REGS-1)*DATA_W-1:0] shadow_flat
);
  logic set_req;
  assign set_req = bus_wr && (bus_addr == '0) && bus_wdata[0];

  // R5: a committed load clears at the vblank that performs it
  a_r5_load_self_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vblank && load_q && aldis_q && !set_req) |=> !load_q);

  // R8: a pending request only goes away through a vblank
  a_r8_load_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_q && !vblank) |=> load_q);

  // R4: active copy holds between vblank pulses
  a_r4_active_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vblank |=> $stable(active_cfg));

  // R6: no request and autoload off means no copy
  a_r6_no_copy_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vblank && aldis_q && !load_q) |=> $stable(active_cfg));

  // R7: autoload copies the pre-edge shadow image
  a_r7_autoload_copy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vblank && !aldis_q) |=> (active_cfg == $past(shadow_flat)));
endmodule

bind cfg_shadow_bank csb_checker #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .vblank      (vblank),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .load_q      (load_q),
  .aldis_q     (aldis_q),
  .active_cfg  (active_cfg),
  .shadow_flat (shadow_flat)
);

// File: tb/cfg_shadow_bank_test.sv
module cfg_shadow_bank_test;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_wdata;
  logic [DW-1:0]     bus_rdata;
  logic              vblank;
  logic [(N-1)*DW-1:0] active_cfg;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [DW-1:0] m_sh [N];
  logic [DW-1:0] m_ac [N];
  bit            m_ald, m_lr;

  always #5 clk = ~clk;

  cfg_shadow_bank #(.NUM_REGS(N), .DATA_W(DW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .vblank     (vblank),
    .active_cfg (active_cfg)
  );

  function automatic logic [DW-1:0] slot(input int k);
    return active_cfg[(k-1)*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
    if (a == 0) return {30'b0, m_ald, m_lr};
    return m_sh[a];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, advance model, compare at next negedge
  task automatic cyc(input bit w, input int a, input logic [DW-1:0] d,
                     input bit vb, input string req);
    bit xf;
    bus_wr = w; bus_addr = AW'(a); bus_wdata = d; vblank = vb;
    xf = vb && (!m_ald || m_lr);
    @(posedge clk);
    @(negedge clk);
    if (xf) for (int k = 1; k < N; k++) m_ac[k] = m_sh[k];
    if (w && a != 0) m_sh[a] = d;
    if (w && a == 0) begin
      m_lr  = d[0] | (m_lr & !xf);
      m_ald = d[1];
    end else m_lr = m_lr & !xf;
    for (int k = 1; k < N; k++) chk(slot(k) === m_ac[k], req, slot(k), m_ac[k]);
    chk(bus_rdata === m_read(bus_addr), req, bus_rdata, m_read(bus_addr));
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string req);
    bus_wr = 0; vblank = 0; bus_addr = AW'(a);
    #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_sh[k] = '0; m_ac[k] = '0; end
    m_ald = 0; m_lr = 0;
    rst_n = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; vblank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) cyc(0, i, '0, 0, "R1");
    for (int k = 0; k < N; k++) rd(k, '0, "R1");

    cyc(1, 3, 32'h0000_00A5, 0, "R2");
    rd(3, 32'h0000_00A5, "R2");
    chk(slot(3) === '0, "R2", slot(3), '0);

    cyc(0, 0, '0, 1, "R7");
    chk(slot(3) === 32'hA5, "R7", slot(3), 32'hA5);

    cyc(1, 0, 32'hFFFF_FFF2, 0, "R3");
    rd(0, 32'h2, "R3");

    cyc(1, 3, 32'h1234, 0, "R6");
    cyc(0, 1, '0, 1, "R6");
    chk(slot(3) === 32'hA5, "R6", slot(3), 32'hA5);

    cyc(1, 0, 32'h3, 0, "R5");
    rd(0, 32'h3, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, "R4");
    chk(slot(3) === 32'hA5, "R4", slot(3), 32'hA5);
    cyc(0, 0, '0, 1, "R5");
    chk(slot(3) === 32'h1234, "R5", slot(3), 32'h1234);
    rd(0, 32'h2, "R5");

    cyc(1, 0, 32'h3, 0, "R8");
    cyc(1, 0, 32'h2, 0, "R8");
    rd(0, 32'h3, "R8");
    cyc(1, 0, 32'h3, 1, "R8");
    rd(0, 32'h3, "R8");
    cyc(0, 0, '0, 1, "R8");
    rd(0, 32'h2, "R8");

    cyc(1, 0, 32'h3, 0, "R9");
    cyc(1, 5, 32'hBEEF, 1, "R9");
    chk(slot(5) === '0, "R9", slot(5), '0);
    rd(5, 32'hBEEF, "R9");
    cyc(1, 0, 32'h3, 0, "R9");
    cyc(0, 0, '0, 1, "R9");
    chk(slot(5) === 32'hBEEF, "R9", slot(5), 32'hBEEF);

    cyc(1, 6, 32'h77, 0, "R7");
    cyc(1, 0, 32'h1, 0, "R7");
    cyc(0, 0, '0, 1, "R7");
    chk(slot(6) === 32'h77, "R7", slot(6), 32'h77);
    rd(0, 32'h0, "R7");

    for (int i = 0; i < 400; i++) begin
      int a;
      a = int'($urandom_range(N-1, 0));
      cyc(($urandom_range(2, 0) != 0), a,
          (a == 0) ? DW'($urandom_range(3, 0)) : DW'($urandom),
          ($urandom_range(5, 0) == 0), "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule